// File: doc/BRIEF.md
# Self-timed page write sequencer

This unit sits behind a serial memory front-end and collects the data bytes of one program frame into a page latch of `PAGE_BYTES` entries. The frame supplies a start address. Each accepted byte is stored at the current page offset, and then only the low offset bits of the address advance. The upper address bits stay fixed for the whole frame. If the frame carries more bytes than the page holds, the offset wraps and later bytes overwrite earlier ones.

When the frame ends, the front-end pulses a frame-end strobe together with a flag. The flag says whether chip select rose exactly on a byte boundary. The unit commits only when all of these hold: the flag is set, at least one byte was loaded, and the external `allow` input is high. On a commit it raises `busy` and writes each loaded (dirty) page entry to the array, one per cycle. It then holds `busy` for a self-timed interval of `BUSY_CYCLES` clocks and ends with a one-cycle `done` pulse. That pulse is the cue for the front-end to clear its write-enable latch. A frame that is rejected drops the page latch and never raises `busy`.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy`, `done` and `arr_we` are 0.
- R2: A byte accepted with `byte_vld` is placed at address {upper bits of the frame start address, page offset}. The offset is the start address low `OFS_W` bits plus the number of bytes accepted before it, modulo `PAGE_BYTES`.
- R3: When more than `PAGE_BYTES` bytes arrive in one frame, a later byte at an offset replaces the earlier one. Only the last value at each offset is written.
- R4: Only offsets loaded in the frame are written to the array. Each is written exactly once, in ascending offset order, one per clock starting the cycle after the commit strobe.
- R5: A frame end with `aligned`=0, with zero bytes loaded, or with `allow`=0 produces no array write and no `busy`. The next frame starts with an empty page.
- R6: On a commit, `busy` rises the cycle after the frame-end strobe. It stays high through the array writes plus `BUSY_CYCLES` further cycles, then falls.
- R7: `done` is a single-cycle pulse in the first cycle after `busy` falls.
- R8: While `busy` is high, `byte_vld`, `frame_start` and `frame_end` are ignored: no page entry changes and no further commit is started.
- R9: `frame_start` loads the start address and clears the page dirty mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Pulse: new program frame, latch `start_addr` |
| start_addr | input | ADDR_W | Frame start address |
| byte_vld | input | 1 | Pulse: `byte_data` is a complete data byte |
| byte_data | input | 8 | Data byte |
| frame_end | input | 1 | Pulse: chip select rose |
| aligned | input | 1 | Chip select rose right after a full byte |
| allow | input | 1 | Protection check passed for this page |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Commit and self-timed interval in progress |
| done | output | 1 | One-cycle end-of-programming pulse |

## Verification
The collisions of interest are a frame-end strobe arriving in the same cycle as the last `byte_vld`, and new frame traffic arriving while `busy` is still high. The bench drives both. It drives `frame_end` together with a final byte and expects that byte to be included in the commit. It sends bytes and a second commit strobe during `busy` and expects the write trace and busy length to be unaffected. Each array write is compared against a model page built from the requirements.

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              frame_end,
  input  logic              aligned,
  input  logic              allow,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data,
  output logic              busy,
  output logic              done
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [1:0] {IDLE, FLUSH, WAIT} st_t;
  st_t st;

  logic [7:0]            page [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] dirty;
  logic [ADDR_W-1:0]     base;
  logic [OFS_W-1:0]      ofs;
  logic [OFS_W-1:0]      scan;
  logic [CNT_W-1:0]      tmr;

  wire take    = byte_vld && st == IDLE;
  wire commit  = frame_end && st == IDLE && aligned && allow && (dirty != '0 || take);
  wire last_sc = scan == OFS_W'(PAGE_BYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty <= '0;
      base  <= '0;
      ofs   <= '0;
    end else if (st == IDLE) begin
      if (frame_start) begin
        base  <= start_addr;
        ofs   <= start_addr[OFS_W-1:0];
        dirty <= '0;
      end else begin
        if (take) begin
          dirty[ofs] <= 1'b1;
          ofs        <= ofs + 1'b1;
        end
        if (frame_end && !commit) dirty <= '0;
      end
    end else if (st == FLUSH) begin
      dirty[scan] <= 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (take && !frame_start) page[ofs] <= byte_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      scan <= '0;
      tmr  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (commit && !frame_start) begin
          st   <= FLUSH;
          scan <= '0;
        end
        FLUSH: begin
          scan <= scan + 1'b1;
          if (last_sc) begin
            st  <= WAIT;
            tmr <= CNT_W'(BUSY_CYCLES);
          end
        end
        default: begin
          if (tmr <= CNT_W'(1)) begin
            st   <= IDLE;
            done <= 1'b1;
          end
          tmr <= tmr - 1'b1;
        end
      endcase
    end
  end

  assign busy     = st != IDLE;
  assign arr_we   = st == FLUSH && dirty[scan];
  assign arr_addr = {base[ADDR_W-1:OFS_W], scan};
  assign arr_data = page[scan];

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R4
  we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  // R5
  no_commit_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !aligned && !busy) |=> !busy);
  // R8
  base_stable_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(base));
endmodule

// File: tb/sim_page_write_seq.sv
module sim_page_write_seq;
  localparam int AW = 13, PB = 32, BC = 40;
  logic clk = 0, rst_n = 0;
  logic frame_start = 0, byte_vld = 0, frame_end = 0, aligned = 0, allow = 0;
  logic [AW-1:0] start_addr = 0;
  logic [7:0] byte_data = 0;
  logic arr_we, busy, done;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_data;
  int vec = 0, bad = 0;

  always #2 clk = ~clk;

  page_write_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .BUSY_CYCLES(BC)) u0 (.*);

  logic [7:0] mdata [PB];
  logic [PB-1:0] mdirty;
  logic [AW-1:0] mbase;
  int mofs;

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, int o);
    return {b[AW-1:5], o[4:0]};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic start(logic [AW-1:0] a);
    frame_start = 1; start_addr = a; tick; frame_start = 0;
    mbase = a; mofs = a[4:0]; mdirty = 0;
  endtask

  task automatic send(logic [7:0] d);
    byte_vld = 1; byte_data = d; tick; byte_vld = 0;
    mdata[mofs] = d; mdirty[mofs] = 1; mofs = (mofs + 1) % PB;
  endtask

  // ends frame; last byte optionally in the same cycle
  task automatic finish(bit al, bit al2, bit with_byte, logic [7:0] d, bit expect_commit, string r);
    int n_we, bl;
    int o;
    frame_end = 1; aligned = al; allow = al2;
    if (with_byte) begin
      byte_vld = 1; byte_data = d;
      mdata[mofs] = d; mdirty[mofs] = 1; mofs = (mofs + 1) % PB;
    end
    tick; frame_end = 0; byte_vld = 0;
    chk({r, " busy rise"}, busy, expect_commit);
    if (!expect_commit) begin
      repeat (3) begin tick; chk({r, " no busy/we"}, {busy, arr_we}, 0); end
      return;
    end
    n_we = 0; bl = 0; o = 0;
    // FLUSH cycles: scan offsets 0..PB-1, plus extra traffic ignored (R8)
    for (int k = 0; k < PB; k++) begin
      chk("R4 we mask", arr_we, mdirty[k]);
      if (arr_we) begin
        n_we++;
        chk("R2 addr", arr_addr, exp_addr(mbase, k));
        chk("R3 data", arr_data, mdata[k]);
      end
      if (k == 3) begin byte_vld = 1; byte_data = 8'hEE; frame_end = 1; aligned = 1; allow = 1; end
      tick; byte_vld = 0; frame_end = 0; bl++;
    end
    chk("R4 count", n_we, $countones(mdirty));
    while (busy && bl < 1000) begin chk("R4 no late we", arr_we, 0); tick; bl++; end
    chk("R6 busy length", bl, PB + BC);
    chk("R7 done", done, 1);
    tick;
    chk("R7 done pulse", done, 0);
    chk("R8 no recommit", busy, 0);
  endtask

  initial begin
    void'($urandom(17));
    #1;
    chk("R1 reset", {busy, done, arr_we}, 0);
    repeat (3) tick;
    rst_n = 1; tick;
    chk("R1 after reset", {busy, done, arr_we}, 0);

    // R2 basic, wrap of start near end of page
    start(13'h0A1C);
    for (int i = 0; i < 6; i++) send(8'h10 + 8'(i));
    finish(1, 1, 0, 0, 1, "R6 basic");

    // R3 overflow: 40 bytes, last in frame-end cycle
    start(13'h1FE5);
    for (int i = 0; i < 39; i++) send(8'($urandom));
    finish(1, 1, 1, 8'h5A, 1, "R3 overflow");

    // R5 unaligned
    start(13'h0040);
    send(8'h11); send(8'h22);
    finish(0, 1, 0, 0, 0, "R5 unaligned");
    // R5 zero bytes
    start(13'h0100);
    finish(1, 1, 0, 0, 0, "R5 empty");
    // R5 not allowed
    start(13'h0100);
    send(8'h33);
    finish(1, 0, 0, 0, 0, "R5 disallowed");
    // R5/R9 discarded page must not leak: end with no bytes after discard
    finish(1, 1, 0, 0, 0, "R5 page dropped");

    // R9 restart mid frame clears mask
    start(13'h0300); send(8'h44); send(8'h55);
    start(13'h0308); send(8'h66);
    finish(1, 1, 0, 0, 1, "R9 restart");

    // random frames
    for (int t = 0; t < 12; t++) begin
      int n; bit al;
      start(AW'($urandom));
      n = 1 + ($urandom % 45);
      for (int i = 0; i < n; i++) send(8'($urandom));
      al = ($urandom % 4) != 0;
      finish(al, 1, 0, 0, al, "R2 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule